// File: doc/BRIEF.md
# Page ECC Spare-Area Sequencer

This block runs single-bit error protection over one flash page held in a byte-wide page buffer. The page is a 2048-byte main area followed by a 64-byte spare area. The main area is split into four 512-byte sections, and each section carries its own 13-bit parity word in a fixed two-byte slot at the start of the spare area. The block masters the buffer port itself: it issues one byte read per cycle and takes the data one cycle later. It writes parity bytes back on the same port.

A program operation walks the sections in address order and folds each section's bytes into a running parity. It then writes the sealed parity into that section's slot, with the three unused upper bits set to 1. A read operation re-walks each section, fetches its stored slot and forms a syndrome. For each section it records clean, corrected (with the failing bit's address) or uncorrectable, plus a worst-case flag for the whole page. The parity word is sealed with a constant chosen so that a fully erased page (all bytes 0xFF) checks as clean. The block only reports a failing bit; correcting the data in the buffer is left to the user.

Top module: `page_ecc_seq`

## Requirements
- R1: After a start, sections are processed strictly in order 0..3. Section k occupies buffer bytes k*512 .. k*512+511. In read mode each section's 512 data reads in ascending address are followed by reads of spare bytes 2048+2k and then 2048+2k+1. In program mode only the 512 data reads occur.
- R2: Section bit i (0..4095) is bit i%8 of section byte i/8. Its code column is 3 for i=0 and 4096+i otherwise. The parity P is the XOR of the columns of all set bits, XOR a seal S, where S is the inverse of the XOR of all 4096 columns. Program writes P[7:0] to byte 2048+2k and {3'b111, P[12:8]} to byte 2048+2k+1.
- R3: Program writes exactly the eight slot bytes 2048..2055 and nothing else. Read never writes. Read and write enables are never high together.
- R4: A read whose syndrome (recomputed parity XOR stored parity) is zero reports that section as clean, code 0.
- R5: A single flipped data bit i in a section is reported as corrected, code 1, with bit address i.
- R6: A single flipped bit j of a stored 13-bit parity word is reported as corrected, code 1, with bit address 4096+j.
- R7: Any other nonzero syndrome, such as two flipped data bits at section bits 5 and 10, is reported as uncorrectable, code 2.
- R8: The upper three bits of each slot's high byte are ignored on read.
- R9: A page with every data and spare byte equal to 0xFF reads as clean in all sections. Programming all-0xFF data writes 0xFF to all eight slot bytes.
- R10: The page worst flag is the highest section code. Done is high for exactly one cycle at the end, after which busy is low. Each start clears all section results to clean.
- R11: Sections are independent: an error in one section does not change another section's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts an operation when idle |
| prog_i | input | 1 | Operation at start: 1 program, 0 read |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| buf_addr_o | output | 12 | Page buffer byte address |
| buf_rd_en_o | output | 1 | Buffer read request, data returns next cycle |
| buf_rd_data_i | input | 8 | Buffer read data |
| buf_wr_en_o | output | 1 | Buffer write strobe |
| buf_wr_data_o | output | 8 | Buffer write data |
| sec_status_o | output | 8 | Section k code at bits [2k+1:2k]: 0 clean, 1 corrected, 2 uncorrectable |
| sec_bit_addr_o | output | 52 | Section k failing bit address at bits [13k+12:13k] |
| page_worst_o | output | 2 | Highest section code |

## Verification
Suppose the parity accumulator takes a byte late, or the return tag mixes up a data byte with a slot byte. The parity written to the spare area is then wrong as soon as that section's slot is written, and on read a clean section shows as corrected or uncorrectable in the result port at the end of the operation. A slip in the section or byte counter shows on the buffer address port at the very next request, and the bench compares every request address against the expected walk. A wrong seal constant shows up as soon as an erased page is read back, and a bad syndrome decode gives a wrong bit address for a single injected flip.

// File: rtl/pgecc_pkg.sv
package pgecc_pkg;

    typedef enum logic [1:0] {
        SEC_CLEAN = 2'd0,
        SEC_FIXED = 2'd1,
        SEC_FATAL = 2'd2
    } sec_stat_e;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_DATA,
        PS_PARITY,
        PS_NEXT,
        PS_DONE
    } phase_e;

    typedef enum logic [1:0] {
        TAG_DATA,
        TAG_LO,
        TAG_HI
    } tag_e;

    // Parity-check column of section bit pos: 3 for bit 0, else top bit | pos.
    function automatic logic [31:0] code_column(input int unsigned pos,
                                                input int unsigned bit_w);
        if (pos == 0) return 32'd3;
        return (32'd1 << bit_w) | 32'(pos);
    endfunction

endpackage

// File: rtl/pgecc_byte_fold.sv
module pgecc_byte_fold
    import pgecc_pkg::*;
#(
    parameter int BIDX_W = 9,
    localparam int BIT_W = BIDX_W + 3,
    localparam int PAR_W = BIT_W + 1
) (
    input  logic [BIDX_W-1:0] byte_idx_i,
    input  logic [7:0]        byte_i,
    output logic [PAR_W-1:0]  fold_o
);

    logic [PAR_W-1:0] lane [8];

    for (genvar j = 0; j < 8; j++) begin : g_lane
        logic [BIT_W-1:0] pos;
        assign pos     = {byte_idx_i, 3'(j)};
        assign lane[j] = byte_i[j] ? PAR_W'(code_column(32'(pos), BIT_W)) : '0;
    end

    always_comb begin
        fold_o = '0;
        for (int j = 0; j < 8; j++) fold_o = fold_o ^ lane[j];
    end

endmodule

// File: rtl/pgecc_syndrome.sv
module pgecc_syndrome
    import pgecc_pkg::*;
#(
    parameter int BIT_W = 12,
    localparam int PAR_W = BIT_W + 1
) (
    input  logic [PAR_W-1:0] syn_i,
    output sec_stat_e        stat_o,
    output logic [PAR_W-1:0] addr_o
);

    logic             single;
    logic [PAR_W-1:0] pos;

    assign single = (syn_i != '0) && ((syn_i & (syn_i - 1'b1)) == '0);

    always_comb begin
        pos = '0;
        for (int b = 0; b < PAR_W; b++) begin
            if (syn_i[b]) pos = PAR_W'(b);
        end
    end

    always_comb begin
        stat_o = SEC_CLEAN;
        addr_o = '0;
        if (syn_i == '0) begin
            stat_o = SEC_CLEAN;
        end else if (syn_i[PAR_W-1] && (syn_i[BIT_W-1:0] != '0)) begin
            stat_o = SEC_FIXED;
            addr_o = {1'b0, syn_i[BIT_W-1:0]};
        end else if (syn_i == PAR_W'(3)) begin
            stat_o = SEC_FIXED;
            addr_o = '0;
        end else if (single) begin
            stat_o = SEC_FIXED;
            addr_o = PAR_W'(1 << BIT_W) + pos;
        end else begin
            stat_o = SEC_FATAL;
        end
    end

endmodule

// File: rtl/pgecc_worst.sv
module pgecc_worst #(
    parameter int NUM_SECT = 4
) (
    input  logic [NUM_SECT-1:0][1:0] stat_i,
    output logic [1:0]               worst_o
);

    always_comb begin
        worst_o = '0;
        for (int k = 0; k < NUM_SECT; k++) begin
            if (stat_i[k] > worst_o) worst_o = stat_i[k];
        end
    end

endmodule

// File: rtl/page_ecc_seq.sv
module page_ecc_seq
    import pgecc_pkg::*;
#(
    parameter int SECT_BYTES  = 512,
    parameter int NUM_SECT    = 4,
    parameter int SPARE_BYTES = 64,
    localparam int BIDX_W     = $clog2(SECT_BYTES),
    localparam int BIT_W      = BIDX_W + 3,
    localparam int PAR_W      = BIT_W + 1,
    localparam int SEC_W      = $clog2(NUM_SECT),
    localparam int DATA_BYTES = SECT_BYTES * NUM_SECT,
    localparam int ADDR_W     = $clog2(DATA_BYTES + SPARE_BYTES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      prog_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic [ADDR_W-1:0]         buf_addr_o,
    output logic                      buf_rd_en_o,
    input  logic [7:0]                buf_rd_data_i,
    output logic                      buf_wr_en_o,
    output logic [7:0]                buf_wr_data_o,
    output logic [2*NUM_SECT-1:0]     sec_status_o,
    output logic [PAR_W*NUM_SECT-1:0] sec_bit_addr_o,
    output logic [1:0]                page_worst_o
);

    localparam int SECT_BITS = SECT_BYTES * 8;
    localparam int SPARE_BASE = DATA_BYTES;
    localparam int SLOT_END = SPARE_BASE + 2 * NUM_SECT;
    localparam logic [BIDX_W-1:0] LAST_BYTE = BIDX_W'(SECT_BYTES - 1);
    localparam logic [SEC_W-1:0]  LAST_SEC  = SEC_W'(NUM_SECT - 1);

    function automatic logic [PAR_W-1:0] erased_fold();
        logic [PAR_W-1:0] x;
        x = '0;
        for (int unsigned i = 0; i < SECT_BITS; i++) x = x ^ PAR_W'(code_column(i, BIT_W));
        return x;
    endfunction

    // Seal makes an all-0xFF section hold an all-ones parity word.
    localparam logic [PAR_W-1:0] SEAL = ~erased_fold();

    typedef struct packed {
        phase_e                          phase;
        logic                            prog;
        logic [SEC_W-1:0]                sec;
        logic [BIDX_W-1:0]               cnt;
        logic [PAR_W-1:0]                acc;
        logic [7:0]                      plo;
        logic [7:0]                      phi;
        logic                            pv;
        tag_e                            ptag;
        logic [BIDX_W-1:0]               pidx;
        logic [NUM_SECT-1:0][1:0]        stat;
        logic [NUM_SECT-1:0][PAR_W-1:0]  baddr;
    } seq_t;

    seq_t q, d;

    logic [PAR_W-1:0] fold;
    logic [PAR_W-1:0] stored;
    logic [PAR_W-1:0] syn;
    logic [15:0]      slot;
    sec_stat_e        dec_stat;
    logic [PAR_W-1:0] dec_addr;
    logic [ADDR_W-1:0] lo_addr;

    pgecc_byte_fold #(.BIDX_W(BIDX_W)) u_fold (
        .byte_idx_i (q.pidx),
        .byte_i     (buf_rd_data_i),
        .fold_o     (fold)
    );

    assign stored = PAR_W'({q.phi, q.plo});
    assign syn    = q.acc ^ SEAL ^ stored;

    pgecc_syndrome #(.BIT_W(BIT_W)) u_syn (
        .syn_i  (syn),
        .stat_o (dec_stat),
        .addr_o (dec_addr)
    );

    pgecc_worst #(.NUM_SECT(NUM_SECT)) u_worst (
        .stat_i  (q.stat),
        .worst_o (page_worst_o)
    );

    always_comb begin
        slot = '1;
        slot[PAR_W-1:0] = q.acc ^ SEAL;
    end

    assign lo_addr = ADDR_W'(SPARE_BASE) + ADDR_W'({q.sec, 1'b0});

    always_comb begin
        d             = q;
        d.pv          = 1'b0;
        buf_rd_en_o   = 1'b0;
        buf_wr_en_o   = 1'b0;
        buf_addr_o    = '0;
        buf_wr_data_o = '0;

        if (q.pv) begin
            case (q.ptag)
                TAG_DATA: d.acc = q.acc ^ fold;
                TAG_LO:   d.plo = buf_rd_data_i;
                TAG_HI:   d.phi = buf_rd_data_i;
                default:  ;
            endcase
        end

        case (q.phase)
            PS_IDLE: begin
                if (start_i) begin
                    d.phase = PS_DATA;
                    d.prog  = prog_i;
                    d.sec   = '0;
                    d.cnt   = '0;
                    d.acc   = '0;
                    d.stat  = '0;
                    d.baddr = '0;
                end
            end
            PS_DATA: begin
                buf_rd_en_o = 1'b1;
                buf_addr_o  = ADDR_W'({q.sec, q.cnt});
                d.pv        = 1'b1;
                d.ptag      = TAG_DATA;
                d.pidx      = q.cnt;
                d.cnt       = q.cnt + 1'b1;
                if (q.cnt == LAST_BYTE) begin
                    d.phase = PS_PARITY;
                    d.cnt   = '0;
                end
            end
            PS_PARITY: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == '0) begin
                    if (!q.prog) begin
                        buf_rd_en_o = 1'b1;
                        buf_addr_o  = lo_addr;
                        d.pv        = 1'b1;
                        d.ptag      = TAG_LO;
                    end
                end else if (q.cnt == BIDX_W'(1)) begin
                    if (q.prog) begin
                        buf_wr_en_o   = 1'b1;
                        buf_addr_o    = lo_addr;
                        buf_wr_data_o = slot[7:0];
                    end else begin
                        buf_rd_en_o = 1'b1;
                        buf_addr_o  = lo_addr + 1'b1;
                        d.pv        = 1'b1;
                        d.ptag      = TAG_HI;
                    end
                end else begin
                    if (q.prog) begin
                        buf_wr_en_o   = 1'b1;
                        buf_addr_o    = lo_addr + 1'b1;
                        buf_wr_data_o = slot[15:8];
                    end
                    d.phase = PS_NEXT;
                    d.cnt   = '0;
                end
            end
            PS_NEXT: begin
                if (!q.prog) begin
                    d.stat[q.sec]  = 2'(dec_stat);
                    d.baddr[q.sec] = dec_addr;
                end
                d.acc = '0;
                if (q.sec == LAST_SEC) begin
                    d.phase = PS_DONE;
                end else begin
                    d.sec   = q.sec + 1'b1;
                    d.phase = PS_DATA;
                end
            end
            PS_DONE: d.phase = PS_IDLE;
            default: d.phase = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PS_IDLE, ptag: TAG_DATA, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o         = (q.phase != PS_IDLE);
    assign done_o         = (q.phase == PS_DONE);
    assign sec_status_o   = q.stat;
    assign sec_bit_addr_o = q.baddr;

    // R3
    wr_only_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en_o |-> q.prog);

    // R3
    wr_in_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en_o |-> (buf_addr_o >= ADDR_W'(SPARE_BASE)) && (buf_addr_o < ADDR_W'(SLOT_END)));

    // R3
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({buf_rd_en_o, buf_wr_en_o}));

    // R1
    sec_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase != PS_IDLE && $past(q.phase) != PS_IDLE) |-> q.sec >= $past(q.sec));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

endmodule

// File: tb/sim_page_ecc_seq.sv
`timescale 1ns/1ps
module sim_page_ecc_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        prog_i = 1'b0;
    logic        busy_o, done_o;
    logic [11:0] buf_addr_o;
    logic        buf_rd_en_o;
    logic [7:0]  buf_rd_data_i = 8'h00;
    logic        buf_wr_en_o;
    logic [7:0]  buf_wr_data_o;
    logic [7:0]  sec_status_o;
    logic [51:0] sec_bit_addr_o;
    logic [1:0]  page_worst_o;

    page_ecc_seq u0 (.*);

    always #2 clk = ~clk;

    logic [7:0] mem  [0:2111];
    logic [7:0] gold [0:2111];
    int n_run = 0, n_fail = 0;
    int rd_n = 0, wr_n = 0, ord_err = 0, done_cyc = 0;
    bit cur_prog = 1'b0;

    function automatic int exp_addr(int n, bit prog);
        int per, k, r;
        per = prog ? 512 : 514;
        k = n / per;
        r = n % per;
        return (r < 512) ? k * 512 + r : 2048 + 2 * k + (r - 512);
    endfunction

    always @(posedge clk) begin
        if (buf_wr_en_o) begin
            mem[buf_addr_o] = buf_wr_data_o;
            wr_n = wr_n + 1;
        end
        if (buf_rd_en_o) begin
            buf_rd_data_i <= mem[buf_addr_o];
            if (int'(buf_addr_o) != exp_addr(rd_n, cur_prog)) ord_err = ord_err + 1;
            rd_n = rd_n + 1;
        end
        if (done_o) done_cyc = done_cyc + 1;
    end

    function automatic logic [12:0] col(int i);
        return (i == 0) ? 13'd3 : 13'(4096 + i);
    endfunction

    function automatic logic [12:0] seal();
        logic [12:0] x = '0;
        for (int i = 0; i < 4096; i++) x ^= col(i);
        return ~x;
    endfunction

    function automatic logic [12:0] sect_parity(int k);
        logic [12:0] x = '0;
        for (int i = 0; i < 4096; i++)
            if (mem[k * 512 + i / 8][i % 8]) x ^= col(i);
        return x ^ seal();
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(bit prog);
        int guard = 0;
        @(negedge clk);
        rd_n = 0; wr_n = 0; ord_err = 0; done_cyc = 0; cur_prog = prog;
        start_i = 1'b1; prog_i = prog;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic restore();
        for (int a = 0; a < 2112; a++) mem[a] = gold[a];
    endtask

    task automatic chk_sec(string req, int k, int st, int ad);
        chk(req, 64'(sec_status_o[2*k +: 2]), 64'(st));
        if (st == 1) chk(req, 64'(sec_bit_addr_o[13*k +: 13]), 64'(ad));
    endtask

    task automatic t_reset();
        chk("R10 busy at reset", 64'(busy_o), 0);
        chk("R10 done at reset", 64'(done_o), 0);
        chk("R3 no access at reset", 64'({buf_rd_en_o, buf_wr_en_o}), 0);
        chk("R10 worst at reset", 64'(page_worst_o), 0);
    endtask

    task automatic t_program();
        logic [12:0] p [4];
        int other = 0;
        for (int a = 0; a < 2048; a++) mem[a] = 8'((a * 37 + (a >> 5) * 11 + 3) ^ (a >> 8));
        for (int a = 2048; a < 2112; a++) mem[a] = 8'h5A;
        for (int k = 0; k < 4; k++) p[k] = sect_parity(k);
        for (int a = 0; a < 2112; a++) gold[a] = mem[a];
        run_op(1'b1);
        for (int k = 0; k < 4; k++) begin
            chk("R2 slot low byte", 64'(mem[2048 + 2*k]), 64'(p[k][7:0]));
            chk("R2 slot high byte", 64'(mem[2049 + 2*k]), 64'({3'b111, p[k][12:8]}));
        end
        for (int a = 0; a < 2112; a++)
            if ((a < 2048 || a >= 2056) && mem[a] !== gold[a]) other++;
        chk("R3 other bytes untouched", 64'(other), 0);
        chk("R3 program write count", 64'(wr_n), 8);
        chk("R1 program read order", 64'(ord_err), 0);
        chk("R1 program read count", 64'(rd_n), 2048);
        chk("R10 done one cycle", 64'(done_cyc), 1);
        chk("R10 idle after done", 64'(busy_o), 0);
        for (int a = 0; a < 2112; a++) gold[a] = mem[a];
    endtask

    task automatic t_read_clean();
        restore();
        run_op(1'b0);
        for (int k = 0; k < 4; k++) chk_sec("R4 clean section", k, 0, 0);
        chk("R10 worst clean", 64'(page_worst_o), 0);
        chk("R1 read order", 64'(ord_err), 0);
        chk("R1 read count", 64'(rd_n), 2056);
        chk("R3 read writes nothing", 64'(wr_n), 0);
    endtask

    task automatic t_single_data();
        restore();
        mem[0][0] ^= 1'b1;
        mem[512 + 777/8][777 % 8] ^= 1'b1;
        mem[1024 + 511][7] ^= 1'b1;
        run_op(1'b0);
        chk_sec("R5 bit 0 section 0", 0, 1, 0);
        chk_sec("R5 bit 777 section 1", 1, 1, 777);
        chk_sec("R5 bit 4095 section 2", 2, 1, 4095);
        chk_sec("R11 untouched section 3", 3, 0, 0);
        chk("R10 worst corrected", 64'(page_worst_o), 1);
    endtask

    task automatic t_parity_flip();
        restore();
        mem[2048][3] ^= 1'b1;
        mem[2055][4] ^= 1'b1;
        run_op(1'b0);
        chk_sec("R6 parity bit 3 section 0", 0, 1, 4096 + 3);
        chk_sec("R6 parity bit 12 section 3", 3, 1, 4096 + 12);
        chk_sec("R11 section 1 clean", 1, 0, 0);
        chk_sec("R11 section 2 clean", 2, 0, 0);
    endtask

    task automatic t_double();
        restore();
        mem[1024][5] ^= 1'b1;
        mem[1025][2] ^= 1'b1;
        mem[12][4] ^= 1'b1;
        run_op(1'b0);
        chk_sec("R7 double error section 2", 2, 2, 0);
        chk_sec("R11 single error section 0", 0, 1, 100);
        chk_sec("R10 results cleared section 1", 1, 0, 0);
        chk_sec("R10 results cleared section 3", 3, 0, 0);
        chk("R10 worst uncorrectable", 64'(page_worst_o), 2);
    endtask

    task automatic t_padding();
        restore();
        for (int k = 0; k < 4; k++) mem[2049 + 2*k] &= 8'h1F;
        run_op(1'b0);
        for (int k = 0; k < 4; k++) chk_sec("R8 padding ignored", k, 0, 0);
    endtask

    task automatic t_erased();
        for (int a = 0; a < 2112; a++) mem[a] = 8'hFF;
        run_op(1'b0);
        for (int k = 0; k < 4; k++) chk_sec("R9 erased page clean", k, 0, 0);
        chk("R9 erased worst", 64'(page_worst_o), 0);
        for (int a = 2048; a < 2056; a++) mem[a] = 8'h00;
        run_op(1'b1);
        for (int a = 2048; a < 2056; a++) chk("R9 erased program slot", 64'(mem[a]), 64'hFF);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_program();
        t_read_clean();
        t_single_data();
        t_parity_flip();
        t_double();
        t_padding();
        t_erased();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule